// File: doc/BRIEF.md
# Audio Limiter Volume Controller

This block watches a stream of signed audio samples, one per sample strobe. When a sample's magnitude reaches a programmable limiter level, it lowers a volume index. A separate gain stage, outside this block, uses that index. The size of each reduction depends on a step-select code and on how far the sample sits above the limiter level. The levels are measured against a full-scale reference that leaves 12 dB of headroom in the sample word.

There are two ways to apply a reduction. In smooth mode, a detected overshoot is held as one pending reduction. That reduction is applied on the first later sample that crosses zero, or when a programmable number of sample periods has gone by. In bypass mode, each overshooting sample removes one volume step at once. The block also pulses a flag when the sample sits in a band just under the limiter level. A recovery controller uses this flag to restart its wait counter.

Top module: `lim_vol_ctrl`

## Requirements
- R1: After reset, `vol_o` equals VOL_DEF (default 128), `rwc_clr_o` is 0, and no reduction is pending.
- R2: While `enable_i` is 0, samples leave `vol_o` unchanged, never raise `rwc_clr_o`, and drop any pending reduction.
- R3: The magnitude is |sample|, with -32768 saturated to 32767. With FS = FS_MAG (default 8000), the limiter level for `thr_sel_i` values 0, 1, 2, 3 is 6000, 4992, 4007 and 3007 (about -2.5, -4.1, -6.0 and -8.5 dB below FS). A hit is a magnitude at or above the selected level.
- R4: The reduction step is set by `step_sel_i` and by the region the magnitude falls in: at or above the level, at or above FS (8000), at or above 2·FS (16000), or at or above 4·FS (32000). For `step_sel_i` = 0 the steps are 1/1/1/1, for 1 they are 2/2/2/2, for 2 they are 2/4/4/8, and for 3 they are 1/2/4/8.
- R5: With `zc_bypass_i` = 1, a hit lowers `vol_o` by exactly 1 in the cycle after its strobe. `step_sel_i` is ignored in this mode.
- R6: With `zc_bypass_i` = 0, a hit with nothing pending latches a pending step and leaves `vol_o` unchanged. The step is applied at the first later strobe whose sample is exactly 0 or has a sign bit that differs from the previous strobed sample.
- R7: If no zero crossing occurs, the pending step is applied at the N-th strobe after the latching strobe, where N = 128 << `tmo_sel_i`.
- R8: Only one reduction is pending at a time. Hits that arrive while a reduction is pending neither add to it nor replace it, and the strobe that applies a step does not latch a new one.
- R9: `vol_o` saturates at 0 and never increases, except through reset.
- R10: `rwc_clr_o` pulses for one cycle after a strobe whose magnitude lies at or above the next lower level and below the selected level. The lower bounds are 4992, 4007, 3007 and 2007 for `thr_sel_i` = 0..3.
- R11: `vol_o` changes only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Signed audio sample |
| sample_vld_i | input | 1 | Sample strobe, one cycle per sample period |
| enable_i | input | 1 | Limiter enable |
| thr_sel_i | input | 2 | Limiter level select |
| step_sel_i | input | 2 | Reduction step select |
| tmo_sel_i | input | 2 | Zero-crossing timeout select |
| zc_bypass_i | input | 1 | 1: step at once by 1; 0: wait for zero crossing or timeout |
| vol_o | output | 8 | Volume index |
| rwc_clr_o | output | 1 | Recovery-wait counter reset pulse |

## Verification
Directed cases cover several distinct effects:
- A loud sample followed by a zero crossing separates a latched reduction from an applied one.
- A long run of same-sign samples after a hit pins the timeout to the exact strobe.
- A second, louder hit while a reduction is pending shows that the first step is neither changed nor added to.
- Bypass runs with step select 2 show that step select is ignored.
- Long bypass runs saturate the volume at zero.
- Disabled runs and the most negative code are also covered.

Random runs draw samples near each level, band edge and region edge, with random configuration changes. They are compared sample by sample against a bench model of all four step tables and the band flag.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int unsigned STP_W = 4;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_THR  = 3'd1,
    RG_FS   = 3'd2,
    RG_FS6  = 3'd3,
    RG_FS12 = 3'd4
  } region_e;

  // level ratios below full scale in Q10: -2.5, -4.1, -6.0, -8.5, -12 dB
  function automatic int unsigned lvl_q10(input int unsigned idx);
    case (idx)
      0:       return 768;
      1:       return 639;
      2:       return 513;
      3:       return 385;
      default: return 257;
    endcase
  endfunction
endpackage

// File: rtl/lim_level_det.sv
module lim_level_det
  import lim_pkg::*;
#(
  parameter int unsigned SMP_W  = 16,
  parameter int unsigned FS_MAG = 8000
) (
  input  logic [SMP_W-1:0] sample_i,
  input  logic [1:0]       thr_sel_i,
  output region_e          region_o,
  output logic             band_o
);
  localparam logic [SMP_W-1:0] MAG_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] NEG_MIN = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic [SMP_W-1:0] FS_L    = SMP_W'(FS_MAG);
  localparam logic [SMP_W-1:0] FS6_L   = SMP_W'(FS_MAG * 2);
  localparam logic [SMP_W-1:0] FS12_L  = SMP_W'(FS_MAG * 4);

  logic [SMP_W-1:0] lvl [5];

  for (genvar i = 0; i < 5; i++) begin : g_lvl
    localparam int unsigned LVL = (FS_MAG * lvl_q10(i)) >> 10;
    assign lvl[i] = SMP_W'(LVL);
  end

  logic [SMP_W-1:0] mag;
  logic [SMP_W-1:0] thr_hi, thr_lo;

  always_comb begin
    if (sample_i == NEG_MIN)    mag = MAG_MAX;
    else if (sample_i[SMP_W-1]) mag = -sample_i;
    else                        mag = sample_i;
  end

  assign thr_hi = lvl[thr_sel_i];
  assign thr_lo = lvl[3'(thr_sel_i) + 3'd1];

  always_comb begin
    if (mag >= FS12_L)      region_o = RG_FS12;
    else if (mag >= FS6_L)  region_o = RG_FS6;
    else if (mag >= FS_L)   region_o = RG_FS;
    else if (mag >= thr_hi) region_o = RG_THR;
    else                    region_o = RG_NONE;
  end

  assign band_o = (mag >= thr_lo) && (mag < thr_hi);
endmodule

// File: rtl/lim_zc_det.sv
module lim_zc_det #(
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] sample_i,
  input  logic             sample_vld_i,
  output logic             zc_o
);
  logic prev_sign_q, prev_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sign_q <= 1'b0;
      prev_vld_q  <= 1'b0;
    end else if (sample_vld_i) begin
      prev_sign_q <= sample_i[SMP_W-1];
      prev_vld_q  <= 1'b1;
    end
  end

  assign zc_o = (sample_i == '0) ||
                (prev_vld_q && (sample_i[SMP_W-1] != prev_sign_q));
endmodule

// File: rtl/lim_step_sel.sv
module lim_step_sel
  import lim_pkg::*;
(
  input  region_e          region_i,
  input  logic [1:0]       step_sel_i,
  output logic [STP_W-1:0] step_o
);
  always_comb begin
    step_o = '0;
    if (region_i != RG_NONE) begin
      unique case (step_sel_i)
        2'd0: step_o = STP_W'(1);
        2'd1: step_o = STP_W'(2);
        2'd2: step_o = (region_i == RG_THR)  ? STP_W'(2) :
                       (region_i == RG_FS12) ? STP_W'(8) : STP_W'(4);
        default: begin
          unique case (region_i)
            RG_THR:  step_o = STP_W'(1);
            RG_FS:   step_o = STP_W'(2);
            RG_FS6:  step_o = STP_W'(4);
            default: step_o = STP_W'(8);
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/lim_vol_ctrl.sv
module lim_vol_ctrl
  import lim_pkg::*;
#(
  parameter int unsigned SMP_W    = 16,
  parameter int unsigned VOL_W    = 8,
  parameter int unsigned VOL_DEF  = 128,
  parameter int unsigned FS_MAG   = 8000,
  parameter int unsigned TMO_BASE = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] sample_i,
  input  logic             sample_vld_i,
  input  logic             enable_i,
  input  logic [1:0]       thr_sel_i,
  input  logic [1:0]       step_sel_i,
  input  logic [1:0]       tmo_sel_i,
  input  logic             zc_bypass_i,
  output logic [VOL_W-1:0] vol_o,
  output logic             rwc_clr_o
);
  localparam int unsigned TMO_MAX = TMO_BASE << 3;
  localparam int unsigned CNT_W   = $clog2(TMO_MAX);

  region_e          region;
  logic             band, zc, hit, expire;
  logic [STP_W-1:0] step_new, step_q;
  logic [VOL_W-1:0] vol_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   period;
  logic             pend_q, rwc_q;

  lim_level_det #(.SMP_W(SMP_W), .FS_MAG(FS_MAG)) u_lvl (
    .sample_i (sample_i),
    .thr_sel_i(thr_sel_i),
    .region_o (region),
    .band_o   (band)
  );

  lim_zc_det #(.SMP_W(SMP_W)) u_zc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_i    (sample_i),
    .sample_vld_i(sample_vld_i),
    .zc_o        (zc)
  );

  lim_step_sel u_step (
    .region_i  (region),
    .step_sel_i(step_sel_i),
    .step_o    (step_new)
  );

  function automatic logic [VOL_W-1:0] sat_sub(input logic [VOL_W-1:0] v,
                                               input logic [STP_W-1:0] s);
    logic [VOL_W-1:0] sw;
    sw = VOL_W'(s);
    return (sw >= v) ? '0 : v - sw;
  endfunction

  assign hit    = (region != RG_NONE);
  assign period = (CNT_W+1)'(TMO_BASE) << tmo_sel_i;
  assign expire = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= period;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q  <= VOL_W'(VOL_DEF);
      pend_q <= 1'b0;
      step_q <= '0;
      cnt_q  <= '0;
      rwc_q  <= 1'b0;
    end else begin
      rwc_q <= sample_vld_i & enable_i & band;
      if (sample_vld_i) begin
        if (!enable_i) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end else if (zc_bypass_i) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
          if (hit) vol_q <= sat_sub(vol_q, STP_W'(1));
        end else if (pend_q) begin
          if (zc || expire) begin
            vol_q  <= sat_sub(vol_q, step_q);
            pend_q <= 1'b0;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else if (hit) begin
          pend_q <= 1'b1;
          step_q <= step_new;
          cnt_q  <= '0;
        end
      end
    end
  end

  assign vol_o     = vol_q;
  assign rwc_clr_o = rwc_q;

  AST_VOL_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_vld_i) |-> $stable(vol_o)); // R11
  AST_VOL_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vol_o <= $past(vol_o)); // R9
  AST_DIS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> $stable(vol_o)); // R2
  AST_BYP_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(zc_bypass_i) && (vol_o != $past(vol_o))) |->
    (($past(vol_o) - vol_o) == VOL_W'(1))); // R5
  AST_RWC_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwc_clr_o |-> $past(sample_vld_i && enable_i)); // R10
endmodule

// File: tb/lim_vol_ctrl_tb_top.sv
module lim_vol_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sample = '0;
  logic        vld = 1'b0, en = 1'b0, byp = 1'b0;
  logic [1:0]  thr = '0, stp = '0, tmo = '0;
  logic [7:0]  vol;
  logic        rwc;

  int n_chk = 0, n_fail = 0;
  int m_vol, m_step, m_cnt, m_prev_sign, m_rwc;
  bit m_pend, m_prev_vld;

  always #10 clk = ~clk;

  lim_vol_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_vld_i(vld),
    .enable_i(en), .thr_sel_i(thr), .step_sel_i(stp), .tmo_sel_i(tmo),
    .zc_bypass_i(byp), .vol_o(vol), .rwc_clr_o(rwc)
  );

  function automatic int lvl(int i);
    int q[5] = '{768, 639, 513, 385, 257};
    return (8000 * q[i]) / 1024;
  endfunction

  function automatic int step_of(int sel, int reg_n);
    int t[4][4] = '{'{1,1,1,1}, '{2,2,2,2}, '{2,4,4,8}, '{1,2,4,8}};
    return t[sel][reg_n-1];
  endfunction

  task automatic model(input logic [15:0] s);
    int v, mag, rg, per;
    bit zc;
    v   = $signed(s);
    mag = (v == -32768) ? 32767 : (v < 0 ? -v : v);
    rg  = (mag >= 32000) ? 4 : (mag >= 16000) ? 3 : (mag >= 8000) ? 2 :
          (mag >= lvl(thr)) ? 1 : 0;
    zc  = (v == 0) || (m_prev_vld && (int'(s[15]) != m_prev_sign));
    per = 128 << tmo;
    m_rwc = en && (mag >= lvl(thr + 1)) && (mag < lvl(thr));
    if (!en) begin
      m_pend = 0; m_cnt = 0;
    end else if (byp) begin
      m_pend = 0; m_cnt = 0;
      if (rg > 0) m_vol = (m_vol > 1) ? m_vol - 1 : 0;
    end else if (m_pend) begin
      if (zc || (m_cnt + 1 >= per)) begin
        m_vol = (m_vol > m_step) ? m_vol - m_step : 0;
        m_pend = 0; m_cnt = 0;
      end else m_cnt++;
    end else if (rg > 0) begin
      m_pend = 1; m_step = step_of(stp, rg); m_cnt = 0;
    end
    m_prev_sign = s[15];
    m_prev_vld  = 1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_vol = 128; m_pend = 0; m_cnt = 0; m_step = 0; m_prev_vld = 0; m_prev_sign = 0;
  endtask

  task automatic send(input int s, input string tag);
    @(negedge clk);
    sample = 16'(s); vld = 1'b1;
    model(16'(s));
    @(negedge clk);
    vld = 1'b0;
    chk(vol == 8'(m_vol), {tag, " vol"}, vol, m_vol);
    chk(rwc == 1'(m_rwc), "R10 rwc", rwc, m_rwc);
  endtask

  function automatic int rnd_sample();
    int k, m;
    k = $urandom_range(0, 9);
    case (k)
      0: m = 0;
      1: m = $urandom_range(1, 2000);
      2: m = lvl($urandom_range(0, 4)) + $urandom_range(0, 2) - 1;
      3: m = 8000 + $urandom_range(0, 2) - 1;
      4: m = 16000 + $urandom_range(0, 2) - 1;
      5: m = 32000 + $urandom_range(0, 2) - 1;
      6: m = $urandom_range(2000, 6500);
      7: return -32768;
      default: m = $urandom_range(0, 32767);
    endcase
    return $urandom_range(0, 1) ? -m : m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    chk(vol == 8'd128, "R1 reset vol", vol, 128);
    chk(rwc == 1'b0, "R1 reset rwc", rwc, 0);

    // bypass: step select ignored, one step per hit
    en = 1; byp = 1; thr = 0; stp = 2;
    send(20000, "R5 bypass");
    chk(vol == 8'd127, "R5 bypass step", vol, 127);
    send(-7000, "R5 bypass neg");

    // smooth mode: latch, hold, apply at crossing; extra hits ignored
    do_reset();
    byp = 0; stp = 2; thr = 0;
    send(20000, "R6 latch");
    chk(vol == 8'd128, "R6 hold", vol, 128);
    send(5000, "R10 band");
    send(32767, "R8 pend hit");
    send(-100, "R6 crossing");
    chk(vol == 8'd124, "R8 single step", vol, 124);
    send(-6000, "R4 step2 thr");
    send(0, "R6 zero");
    chk(vol == 8'd122, "R4 step2 thr", vol, 122);

    // timeout with no crossing
    do_reset();
    stp = 3; tmo = 0;
    send(32767, "R7 latch");
    for (int i = 0; i < 127; i++) send(100, "R7 wait");
    chk(vol == 8'd128, "R7 before expiry", vol, 128);
    send(100, "R7 expiry");
    chk(vol == 8'd120, "R7 at expiry", vol, 120);

    // most negative code in region FS12
    do_reset();
    send(-32768, "R3 min code");
    send(5, "R3 min code apply");
    chk(vol == 8'd120, "R3 min code", vol, 120);

    // disabled: no change, no flag
    do_reset();
    en = 0;
    for (int i = 0; i < 6; i++) send((i % 2) ? -30000 : 5500, "R2 disabled");
    chk(vol == 8'd128, "R2 disabled", vol, 128);

    // saturation at zero
    do_reset();
    en = 1; byp = 1;
    for (int i = 0; i < 135; i++) send(9000, "R9 saturate");
    chk(vol == 8'd0, "R9 floor", vol, 0);

    // random segments
    for (int seg = 0; seg < 6; seg++) begin
      do_reset();
      for (int i = 0; i < 500; i++) begin
        if (i % 40 == 0) begin
          en  = ($urandom_range(0, 7) != 0);
          byp = ($urandom_range(0, 3) == 0);
          thr = 2'($urandom_range(0, 3));
          stp = 2'($urandom_range(0, 3));
          tmo = 2'($urandom_range(0, 1));
        end
        send(rnd_sample(), "R4 random");
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          chk(vol == 8'(m_vol), "R11 idle vol", vol, m_vol);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule